// File: doc/BRIEF.md
# Speculative Load Alias Detector

This block lets a scheduler hoist loads above earlier stores safely. When a hoisted load is issued as a protected load, the block records the byte range it read (start address plus access width) in one of a small set of region slots. A store that was moved below such loads is issued as a masked store. The block compares its byte range with every live region. If any byte is shared, the speculation was unsafe, and the block pulses a fault so that recovery can restore checkpointed state and re-run the code conservatively.

All requests share one request port with a two-bit kind field. Plain loads and plain stores also pass through this port but leave the block untouched. A clear input, pulsed on commit or on rollback, empties every region in a single cycle. A protected load that finds every slot occupied cannot be tracked, so it raises the same fault as a detected alias. The fault output is registered: it is high for exactly one cycle, in the cycle after the offending request.

Top module: `spec_alias_guard`

## Requirements
- R1: A protected load (kind 2) that finds a free slot while clear is low records its start address and width, and raises no fault; a later masked store that overlaps that range faults.
- R2: A request with size code s covers the bytes from addr to addr + 2^s - 1 (codes 0, 1, 2, 3 give 1, 2, 4, 8 bytes). This end is computed one bit wider than the address, so a range never wraps past the top of the address space to address 0.
- R3: A protected load presented while all NUM_REGIONS slots are occupied raises the fault, and it is not recorded.
- R4: The fault output goes high in the cycle after an offending request and stays high for that one cycle only. It is never high unless the previous cycle held a protected load or masked store with clear low.
- R5: When clear is high, all regions become empty at the next edge. Any request in the same cycle is ignored and raises no fault.
- R6: Plain loads (kind 0) and plain stores (kind 1) neither change the regions nor raise the fault.
- R7: After reset no region is occupied and the fault output is low.
- R8: A masked store (kind 3) never adds or removes a region, whether or not it faults.
- R9: A masked store whose byte range shares no byte with any live region raises no fault. Ranges that only touch end to end do not overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Commit or rollback pulse; empties all regions |
| req_valid_i | input | 1 | A request is present this cycle |
| req_kind_i | input | 2 | 0 plain load, 1 plain store, 2 protected load, 3 masked store |
| req_addr_i | input | ADDR_W | Byte start address of the access |
| req_size_i | input | 2 | Log2 of the access width in bytes |
| exc_o | output | 1 | One-cycle alias or overflow fault |

## Verification
The region table is not visible at the ports. A wrong entry therefore shows up only as a fault that is wrongly present or wrongly absent, one cycle after a later masked store or protected load probes it. A stale valid bit gives a spurious alias on the first overlapping store. A lost or misplaced range gives a missing alias. A miscounted slot shows as an overflow fault arriving one load early or one load late. The bench therefore sweeps store ranges densely around known regions and fills the table up to and beyond its capacity, so that each kind of corruption is seen within one request.

// File: rtl/alias_guard_pkg.sv
package alias_guard_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_PLOAD  = 2'd2,
        OP_MSTORE = 2'd3
    } op_kind_e;

    // Width in bytes for a log2 size code.
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/alias_range_cmp.sv
module alias_range_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] a_base_i,
    input  logic [1:0]        a_size_i,
    input  logic [ADDR_W-1:0] b_base_i,
    input  logic [1:0]        b_size_i,
    output logic              overlap_o
);
    import alias_guard_pkg::*;

    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] a_lo, a_end, b_lo, b_end;

    // Ends are exclusive and one bit wider, so no range wraps.
    always_comb begin
        a_lo      = {1'b0, a_base_i};
        b_lo      = {1'b0, b_base_i};
        a_end     = a_lo + EXT_W'(size_bytes(a_size_i));
        b_end     = b_lo + EXT_W'(size_bytes(b_size_i));
        overlap_o = (a_lo < b_end) && (b_lo < a_end);
    end

endmodule

// File: rtl/alias_free_pick.sv
module alias_free_pick #(
    parameter int NUM_SLOTS = 8
) (
    input  logic [NUM_SLOTS-1:0] busy_i,
    output logic                 found_o,
    output logic [(NUM_SLOTS > 1 ? $clog2(NUM_SLOTS) : 1)-1:0] idx_o
);
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    // Lowest free slot wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/spec_alias_guard.sv
module spec_alias_guard #(
    parameter int ADDR_W      = 16,
    parameter int NUM_REGIONS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    output logic              exc_o
);
    import alias_guard_pkg::*;

    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    typedef struct packed {
        logic [NUM_REGIONS-1:0]             vld;
        logic [NUM_REGIONS-1:0][ADDR_W-1:0] base;
        logic [NUM_REGIONS-1:0][1:0]        sz;
        logic                               exc;
    } guard_state_t;

    guard_state_t st_d, st_q;

    logic [NUM_REGIONS-1:0] cmp_hit;
    logic [NUM_REGIONS-1:0] live_hit;
    logic                   slot_found;
    logic [IDX_W-1:0]       slot_idx;
    logic [NUM_REGIONS-1:0] region_vld;

    // One range comparator per region slot.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        alias_range_cmp #(
            .ADDR_W (ADDR_W)
        ) u_cmp (
            .a_base_i  (st_q.base[g]),
            .a_size_i  (st_q.sz[g]),
            .b_base_i  (req_addr_i),
            .b_size_i  (req_size_i),
            .overlap_o (cmp_hit[g])
        );
    end

    assign live_hit = cmp_hit & st_q.vld;

    alias_free_pick #(
        .NUM_SLOTS (NUM_REGIONS)
    ) u_pick (
        .busy_i  (st_q.vld),
        .found_o (slot_found),
        .idx_o   (slot_idx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.exc = 1'b0;
        if (clear_i) begin
            st_d.vld = '0;
        end else if (req_valid_i) begin
            unique case (op_kind_e'(req_kind_i))
                OP_PLOAD: begin
                    if (slot_found) begin
                        st_d.vld[slot_idx]  = 1'b1;
                        st_d.base[slot_idx] = req_addr_i;
                        st_d.sz[slot_idx]   = req_size_i;
                    end else begin
                        st_d.exc = 1'b1;
                    end
                end
                OP_MSTORE: st_d.exc = |live_hit;
                default:   st_d.exc = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_o      = st_q.exc;
    assign region_vld = st_q.vld;

endmodule

// File: rtl/spec_alias_guard_chk.sv
module spec_alias_guard_chk #(
    parameter int NUM_REGIONS = 8
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   clear_i,
    input logic                   req_valid_i,
    input logic [1:0]             req_kind_i,
    input logic                   exc_o,
    input logic [NUM_REGIONS-1:0] vld_i
);
    logic pl_req, ms_req, plain_req;
    assign pl_req    = req_valid_i && !clear_i && (req_kind_i == 2'd2);
    assign ms_req    = req_valid_i && !clear_i && (req_kind_i == 2'd3);
    assign plain_req = req_valid_i && !clear_i && !req_kind_i[1];

    // R4: a fault follows only a checked request
    a_r4_exc_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_o |-> $past(pl_req || ms_req));

    // R5: clear empties the table and suppresses faults
    a_r5_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (vld_i == '0) && !exc_o);

    // R6: plain traffic is inert
    a_r6_plain_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        plain_req |=> !exc_o && $stable(vld_i));

    // R3: a protected load into a full table faults and records nothing
    a_r3_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pl_req && (&vld_i)) |=> exc_o && $stable(vld_i));

    // R1: a protected load with room takes exactly one slot
    a_r1_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pl_req && !(&vld_i)) |=> !exc_o &&
            ($countones(vld_i) == $countones($past(vld_i)) + 1));

    // R8: masked stores leave the table alone
    a_r8_store_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ms_req |=> $stable(vld_i));

endmodule

bind spec_alias_guard spec_alias_guard_chk #(
    .NUM_REGIONS (NUM_REGIONS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .exc_o       (exc_o),
    .vld_i       (region_vld)
);

// File: tb/tb_spec_alias_guard.sv
module tb_spec_alias_guard;

    localparam int AW = 16;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd0;
    logic          exc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_base[NR];
    int m_len[NR];
    int m_cnt = 0;

    always #4 clk = ~clk;

    spec_alias_guard #(.ADDR_W(AW), .NUM_REGIONS(NR)) dut (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
        .req_valid_i(req_valid), .req_kind_i(req_kind),
        .req_addr_i(req_addr), .req_size_i(req_size), .exc_o(exc)
    );

    task automatic check(input string req, input logic act, input logic expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: exc actual %0b expected %0b", req, act, expv);
        end
    endtask

    // Drive at a falling edge, sample the registered fault one edge later.
    task automatic op(input bit v, input int kind, input int addr, input int sz,
                      input bit clr, input string req);
        logic expv;
        int   len;
        req_valid = v; req_kind = 2'(kind); req_addr = AW'(addr);
        req_size = 2'(sz); clear = clr;
        @(negedge clk);
        len  = 1 << sz;
        expv = 1'b0;
        if (clr) begin
            m_cnt = 0;
        end else if (v && kind == 2) begin
            if (m_cnt == NR) expv = 1'b1;
            else begin m_base[m_cnt] = addr; m_len[m_cnt] = len; m_cnt++; end
        end else if (v && kind == 3) begin
            for (int i = 0; i < m_cnt; i++)
                if (addr < m_base[i] + m_len[i] && m_base[i] < addr + len) expv = 1'b1;
        end
        check(req, exc, expv);
        req_valid = 1'b0; clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset", exc, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after reset", exc, 1'b0);
        op(1, 3, 0, 3, 0, "R7 empty table store");

        // R1 R2 R9: single region of every width, stores swept around it
        for (int ps = 0; ps < 4; ps++) begin
            op(0, 0, 0, 0, 1, "R5 clear");
            op(1, 2, 16, ps, 0, "R1 protect");
            for (int a = 8; a < 32; a++)
                for (int ss = 0; ss < 4; ss++)
                    op(1, 3, a, ss, 0, "R2 R9 overlap sweep");
        end

        // R4: pulse lasts one cycle
        op(0, 0, 0, 0, 1, "R5 clear");
        op(1, 2, 40, 2, 0, "R1 protect");
        op(1, 3, 42, 0, 0, "R4 hit");
        op(0, 0, 0, 0, 0, "R4 pulse ends");
        op(1, 3, 43, 0, 0, "R4 back to back hit");
        op(1, 3, 41, 1, 0, "R4 back to back hit");

        // R6: plain traffic over a live region
        op(1, 1, 40, 3, 0, "R6 plain store");
        op(1, 0, 40, 3, 0, "R6 plain load");
        op(1, 3, 44, 0, 0, "R6 no region added");
        op(1, 3, 40, 0, 0, "R6 region kept");

        // R5: clear with a same-cycle request
        op(1, 3, 40, 0, 1, "R5 store during clear");
        op(1, 3, 40, 3, 0, "R5 table empty");
        op(1, 2, 40, 0, 1, "R5 load during clear");
        op(1, 3, 40, 0, 0, "R5 load ignored");

        // R3 R8: fill every slot, then overflow
        for (int i = 0; i < NR; i++) op(1, 2, i * 32 + (i % 4), i % 4, 0, "R1 fill");
        for (int a = 0; a < 272; a++) op(1, 3, a, a % 4, 0, "R8 R9 multi sweep");
        op(1, 2, 1000, 0, 0, "R3 overflow");
        op(1, 3, 1000, 0, 0, "R3 not recorded");
        op(1, 2, 1004, 0, 0, "R3 overflow again");

        // R2: top of address space does not wrap
        op(0, 0, 0, 0, 1, "R5 clear");
        op(1, 2, 16'hFFF8, 3, 0, "R1 protect top");
        op(1, 3, 0, 3, 0, "R2 no wrap");
        op(1, 3, 16'hFFFF, 0, 0, "R2 last byte");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule